// File: doc/BRIEF.md
# Fault Injection Location Sequencer

This block steers a configuration-memory upset campaign. It decides which configuration bit gets flipped next and when the original frame contents must be written back. A location is a frame index inside a programmable window, plus a bit offset inside that frame. The block issues each location as an inject command and then waits for the outcome of the functional test that follows the injection. Depending on the policy, it then issues restore commands for the frames it has disturbed.

Three policies are available, picked by `cfg_mode`:

- **Exhaustive sweep (0):** every bit of the window in increasing order. The frame is repaired after every test.
- **Random build-up (1):** random locations with no repair, so upsets pile up.
- **Random with periodic repair (2):** random locations. Every frame touched since the previous repair is rewritten once a chosen number of injections is reached.

A stop rule can end the campaign early. It can stop at the first failing test, or after a given number of flips, or it can be switched off. Commands leave over a valid/ready handshake. Test results arrive as a single-cycle `res_valid` pulse.

Top module: `fis_loc_sequencer`

## Requirements
- R1: While and right after reset, `cmd_valid`, `done` and `inj_count` are all zero.
- R2: In mode 0, inject locations run over frames `cfg_first` to `cfg_last`. Inside each frame the offset runs from 0 to FRAME_BITS-1, so the linear address frame*FRAME_BITS+offset strictly increases. Inject commands carry `cmd_restore`=0 and `cmd_last`=1.
- R3: In mode 0, every inject is followed, after its test result, by exactly one restore command (`cmd_restore`=1, offset 0, `cmd_last`=1) for the same frame, before the next inject.
- R4: In mode 0, `done` rises after the restore that follows the last bit of frame `cfg_last`. While `done` is high, no command is offered.
- R5: In modes 1 and 2, a 32-bit Galois LFSR is loaded at start with `cfg_seed`, or with 1 if the seed is zero. The LFSR steps right with mask 0x80200003. Each state is a candidate whose frame is bits [ADDR_W-1:0] and whose offset is the next OFF_W bits. Candidates with a frame outside the window, or an offset of FRAME_BITS or more, are dropped. Accepted candidates are injected in stream order.
- R6: Mode 1 never issues a restore command.
- R7: In mode 2, once the number of injections since the last repair equals `cfg_clean_n`, or the frame table (TBL_DEPTH entries) is full, the block restores every frame injected since that repair. It does so in injection order, duplicates included, and sets `cmd_last` only on the final one.
- R8: With `cfg_stop`=1, the first failing result ends the run. Any restore that the mode calls for is still issued, and then `done` rises.
- R9: With `cfg_stop`=2, the run ends after `cfg_max_flips` injections, again after any restore that the mode calls for.
- R10: `inj_count` rises by one per accepted inject command and is cleared by `start`.
- R11: A command offered with `cmd_ready` low stays valid and unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latch configuration and begin a campaign (accepted when idle or done) |
| cfg_mode | input | 2 | 0 sweep, 1 random build-up, 2 random with periodic repair |
| cfg_stop | input | 2 | 0 never, 1 first failing test, 2 after cfg_max_flips injections |
| cfg_first | input | ADDR_W | First frame of the window |
| cfg_last | input | ADDR_W | Last frame of the window (not below cfg_first) |
| cfg_seed | input | 32 | LFSR seed |
| cfg_clean_n | input | TBL_AW+1 | Injections between repairs in mode 2 |
| cfg_max_flips | input | CNT_W | Injection limit for stop rule 2 |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command accepted |
| cmd_restore | output | 1 | 1 restore frame, 0 inject bit |
| cmd_frame | output | ADDR_W | Frame index |
| cmd_bit | output | OFF_W | Bit offset inside the frame |
| cmd_last | output | 1 | Final command of the current group |
| res_valid | input | 1 | Test result strobe |
| res_fail | input | 1 | Test result failed |
| inj_count | output | CNT_W | Injections completed |
| done | output | 1 | Campaign finished |

## Verification
The bench builds the block with ADDR_W=4, FRAME_BITS=4 and TBL_DEPTH=4.

A 16-frame address space lets random candidates land both inside and outside narrow windows, so rejection is exercised within a few draws. A four-entry table lets a repair interval of 5 run into the table-full trigger. A window of three frames keeps the full sweep to twelve injections, which puts the exhaustion point and the single-frame window within reach.

// File: rtl/fis_pkg.sv
package fis_pkg;
  typedef enum logic [1:0] {MODE_SEQ = 2'd0, MODE_ACC = 2'd1, MODE_ACL = 2'd2} fis_mode_e;
  typedef enum logic [1:0] {STOP_NONE = 2'd0, STOP_FAIL = 2'd1, STOP_COUNT = 2'd2} fis_stop_e;
  typedef enum logic [2:0] {ST_IDLE, ST_PICK, ST_INJ, ST_WAIT, ST_RST, ST_NEXT, ST_DONE} fis_state_e;
  localparam logic [31:0] LFSR_MASK = 32'h80200003;
endpackage

// File: rtl/fis_lfsr.sv
module fis_lfsr (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [31:0] seed,
  input  logic        step,
  output logic [31:0] value
);
  import fis_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) value <= 32'd1;
    else if (load) value <= (seed == 32'd0) ? 32'd1 : seed;
    else if (step) value <= value[0] ? ((value >> 1) ^ LFSR_MASK) : (value >> 1);
  end

  // the all-zero state would lock the generator
  assert_lfsr_live_R5: assert property (@(posedge clk) disable iff (rst) value != 32'd0);
endmodule

// File: rtl/fis_frame_table.sv
module fis_frame_table #(
  parameter int DEPTH = 16,
  parameter int DW    = 12,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fis_loc_sequencer.sv
module fis_loc_sequencer #(
  parameter int ADDR_W     = 12,
  parameter int FRAME_BITS = 1312,
  parameter int TBL_DEPTH  = 16,
  parameter int CNT_W      = 16,
  localparam int OFF_W     = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1,
  localparam int TBL_AW    = $clog2(TBL_DEPTH),
  localparam int TC_W      = TBL_AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        cfg_stop,
  input  logic [ADDR_W-1:0] cfg_first,
  input  logic [ADDR_W-1:0] cfg_last,
  input  logic [31:0]       cfg_seed,
  input  logic [TC_W-1:0]   cfg_clean_n,
  input  logic [CNT_W-1:0]  cfg_max_flips,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_restore,
  output logic [ADDR_W-1:0] cmd_frame,
  output logic [OFF_W-1:0]  cmd_bit,
  output logic              cmd_last,
  input  logic              res_valid,
  input  logic              res_fail,
  output logic [CNT_W-1:0]  inj_count,
  output logic              done
);
  import fis_pkg::*;

  fis_state_e        state;
  fis_mode_e         mode_q;
  fis_stop_e         stop_q;
  logic [ADDR_W-1:0] first_q, last_q, cur_frame;
  logic [OFF_W-1:0]  cur_bit;
  logic [TC_W-1:0]   clean_q, tbl_cnt, rd_ptr;
  logic [CNT_W-1:0]  max_q;
  logic              stop_pend;
  logic [31:0]       lfsr_q;
  logic [ADDR_W-1:0] tbl_rdata;

  wire launch = start && (state == ST_IDLE || state == ST_DONE);
  wire lfsr_step = (state == ST_PICK) && (mode_q != MODE_SEQ);

  fis_lfsr u_lfsr (
    .clk(clk), .rst(rst), .load(launch), .seed(cfg_seed), .step(lfsr_step), .value(lfsr_q)
  );

  fis_frame_table #(.DEPTH(TBL_DEPTH), .DW(ADDR_W)) u_table (
    .clk(clk), .we(state == ST_INJ && cmd_ready), .waddr(tbl_cnt[TBL_AW-1:0]),
    .wdata(cmd_frame), .raddr(rd_ptr[TBL_AW-1:0]), .rdata(tbl_rdata)
  );

  wire [ADDR_W-1:0] cand_frame = lfsr_q[ADDR_W-1:0];
  wire [OFF_W-1:0]  cand_bit   = lfsr_q[ADDR_W +: OFF_W];
  wire cand_ok = (cand_frame >= first_q) && (cand_frame <= last_q) &&
                 (32'(cand_bit) < 32'(FRAME_BITS));
  wire clean_hit = (tbl_cnt == clean_q) || (tbl_cnt == TC_W'(TBL_DEPTH));
  wire bit_end   = (cur_bit == OFF_W'(FRAME_BITS - 1));
  wire seq_end   = (cur_frame == last_q) && bit_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; mode_q <= MODE_SEQ; stop_q <= STOP_NONE;
      first_q <= '0; last_q <= '0; cur_frame <= '0; cur_bit <= '0;
      clean_q <= '0; tbl_cnt <= '0; rd_ptr <= '0; max_q <= '0; stop_pend <= 1'b0;
      cmd_valid <= 1'b0; cmd_restore <= 1'b0; cmd_frame <= '0; cmd_bit <= '0;
      cmd_last <= 1'b0; inj_count <= '0; done <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: if (launch) begin
          mode_q <= fis_mode_e'(cfg_mode); stop_q <= fis_stop_e'(cfg_stop);
          first_q <= cfg_first; last_q <= cfg_last; clean_q <= cfg_clean_n;
          max_q <= cfg_max_flips; cur_frame <= cfg_first; cur_bit <= '0;
          tbl_cnt <= '0; inj_count <= '0; stop_pend <= 1'b0; done <= 1'b0;
          state <= ST_PICK;
        end
        ST_PICK: begin
          if (mode_q == MODE_SEQ) begin
            cmd_frame <= cur_frame; cmd_bit <= cur_bit;
            cmd_restore <= 1'b0; cmd_last <= 1'b1; cmd_valid <= 1'b1;
            state <= ST_INJ;
          end else if (cand_ok) begin
            cmd_frame <= cand_frame; cmd_bit <= cand_bit;
            cmd_restore <= 1'b0; cmd_last <= 1'b1; cmd_valid <= 1'b1;
            state <= ST_INJ;
          end
        end
        ST_INJ: if (cmd_ready) begin
          cmd_valid <= 1'b0;
          tbl_cnt   <= tbl_cnt + 1'b1;
          inj_count <= inj_count + 1'b1;
          state     <= ST_WAIT;
        end
        ST_WAIT: if (res_valid) begin
          stop_pend <= (stop_q == STOP_FAIL && res_fail) ||
                       (stop_q == STOP_COUNT && inj_count == max_q);
          rd_ptr <= '0;
          if (mode_q == MODE_SEQ || (mode_q == MODE_ACL && clean_hit)) state <= ST_RST;
          else state <= ST_NEXT;
        end
        ST_RST: begin
          if (!cmd_valid) begin
            cmd_frame <= tbl_rdata; cmd_bit <= '0; cmd_restore <= 1'b1;
            cmd_last <= (rd_ptr == tbl_cnt - 1'b1); cmd_valid <= 1'b1;
          end else if (cmd_ready) begin
            cmd_valid <= 1'b0;
            if (cmd_last) begin
              tbl_cnt <= '0;
              state <= ST_NEXT;
            end else begin
              rd_ptr <= rd_ptr + 1'b1;
            end
          end
        end
        ST_NEXT: begin
          if (stop_pend || (mode_q == MODE_SEQ && seq_end)) begin
            done <= 1'b1;
            state <= ST_DONE;
          end else begin
            if (mode_q == MODE_SEQ) begin
              if (bit_end) begin
                cur_bit <= '0;
                cur_frame <= cur_frame + 1'b1;
              end else begin
                cur_bit <= cur_bit + 1'b1;
              end
            end
            state <= ST_PICK;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_frame) && $stable(cmd_bit)
                                && $stable(cmd_restore) && $stable(cmd_last));
  assert_window_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_restore |-> cmd_frame >= first_q && cmd_frame <= last_q);
  assert_no_repair_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && mode_q == MODE_ACC |-> !cmd_restore);
  assert_count_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready && !cmd_restore |=> inj_count == CNT_W'($past(inj_count) + 1'b1));
  assert_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> !cmd_valid);
endmodule

// File: tb/tb_fis_loc_sequencer.sv
module tb_fis_loc_sequencer;
  localparam int AW = 4, FB = 4, TD = 4, CNTW = 16, TCW = 3, OFW = 2;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [1:0] cfg_mode = '0, cfg_stop = '0;
  logic [AW-1:0] cfg_first = '0, cfg_last = '0;
  logic [31:0] cfg_seed = '0;
  logic [TCW-1:0] cfg_clean_n = '0;
  logic [CNTW-1:0] cfg_max_flips = '0;
  logic cmd_valid, cmd_restore, cmd_last, done;
  logic cmd_ready = 1'b0, res_valid = 1'b0, res_fail = 1'b0;
  logic [AW-1:0] cmd_frame;
  logic [OFW-1:0] cmd_bit;
  logic [CNTW-1:0] inj_count;

  fis_loc_sequencer #(.ADDR_W(AW), .FRAME_BITS(FB), .TBL_DEPTH(TD), .CNT_W(CNTW)) dut (
    .clk(clk), .rst(rst), .start(start), .cfg_mode(cfg_mode), .cfg_stop(cfg_stop),
    .cfg_first(cfg_first), .cfg_last(cfg_last), .cfg_seed(cfg_seed),
    .cfg_clean_n(cfg_clean_n), .cfg_max_flips(cfg_max_flips), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_restore(cmd_restore), .cmd_frame(cmd_frame),
    .cmd_bit(cmd_bit), .cmd_last(cmd_last), .res_valid(res_valid), .res_fail(res_fail),
    .inj_count(inj_count), .done(done));

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0, inj_idx = 0, fail_at = 0, pend = 0, hold_val = 0;
  int exp_q[$];
  bit rdy_all = 1'b0, hold_prev = 1'b0, finished = 1'b0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int enc(input bit r, input bit l, input int f, input int b);
    return (int'(r) << 17) | (int'(l) << 16) | (f << 8) | b;
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] v);
    return v[0] ? ((v >> 1) ^ 32'h80200003) : (v >> 1);
  endfunction

  // behavioural reference: full expected command list of one campaign
  task automatic build(input int mode, input int first, input int last, input logic [31:0] seed,
                       input int clean, input int stop, input int maxf, input int fat,
                       output int ninj);
    int tbl[$];
    int f, b, fr, bt, k;
    bit stp;
    logic [31:0] v;
    exp_q.delete();
    f = first; b = 0; k = 0;
    v = (seed == 0) ? 32'd1 : seed;
    while (1) begin
      if (mode == 0) begin
        fr = f; bt = b;
      end else begin
        while (1) begin
          fr = int'(v[3:0]); bt = int'(v[5:4]);
          v = nxt(v);
          if (fr >= first && fr <= last && bt < FB) break;
        end
      end
      exp_q.push_back(enc(1'b0, 1'b1, fr, bt));
      tbl.push_back(fr);
      k++;
      stp = (stop == 1 && k == fat) || (stop == 2 && k == maxf);
      if (mode == 0 || (mode == 2 && (tbl.size() == clean || tbl.size() == TD))) begin
        foreach (tbl[i]) exp_q.push_back(enc(1'b1, i == tbl.size() - 1, tbl[i], 0));
        tbl.delete();
      end
      if (stp) break;
      if (mode == 0) begin
        if (f == last && b == FB - 1) break;
        if (b == FB - 1) begin b = 0; f++; end else b++;
      end
    end
    ninj = k;
  endtask

  always @(negedge clk) begin
    int act;
    cyc++;
    act = enc(cmd_restore, cmd_last, int'(cmd_frame), int'(cmd_bit));
    if (hold_prev) chk(cmd_valid && act == hold_val, "R11", act, hold_val);
    res_valid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        res_valid = 1'b1;
        res_fail = (inj_idx == fail_at);
      end
    end
    cmd_ready = !rst && (rdy_all || (cyc % 3 != 0));
    if (cmd_valid && cmd_ready) begin
      if (exp_q.size() == 0) chk(1'b0, cur_req, act, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(act == e, cur_req, act, e);
      end
      if (!cmd_restore) begin
        inj_idx++;
        pend = 3;
      end
    end
    hold_prev = cmd_valid && !cmd_ready;
    hold_val = act;
  end

  task automatic run(input string req, input int mode, input int first, input int last,
                     input logic [31:0] seed, input int clean, input int stop, input int maxf,
                     input int fat, input bit fast);
    int ninj, t;
    build(mode, first, last, seed, clean, stop, maxf, fat, ninj);
    cur_req = req; rdy_all = fast; inj_idx = 0; fail_at = fat;
    cfg_mode = 2'(mode); cfg_first = AW'(first); cfg_last = AW'(last); cfg_seed = seed;
    cfg_clean_n = TCW'(clean); cfg_stop = 2'(stop); cfg_max_flips = CNTW'(maxf);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(done == 1'b1, "R4 done", int'(done), 1);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    chk(int'(inj_count) == ninj, "R10 count", int'(inj_count), ninj);
    repeat (5) @(negedge clk);
    chk(!cmd_valid && done, "R4 quiet", int'(cmd_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!cmd_valid && !done && inj_count == 0, "R1", int'(inj_count), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!cmd_valid && !done && inj_count == 0, "R1", int'(cmd_valid), 0);
    run("R2 R3 sweep",        0, 3, 5,  32'h0,    1, 0, 0, 0, 1'b0);
    run("R8 first fail",      0, 2, 9,  32'h0,    1, 1, 0, 3, 1'b1);
    run("R5 R6 R9 build-up",  1, 5, 11, 32'hACE1, 1, 2, 6, 0, 1'b0);
    run("R5 zero seed",       1, 0, 15, 32'h0,    1, 2, 3, 0, 1'b1);
    run("R7 periodic repair", 2, 0, 15, 32'h1234, 3, 2, 7, 0, 1'b0);
    run("R7 table full",      2, 2, 13, 32'hBEEF, 5, 2, 5, 0, 1'b0);
    run("R9 single frame",    0, 7, 7,  32'h0,    1, 2, 2, 0, 1'b0);
    run("R8 build-up fail",   1, 1, 14, 32'h00C0FFEE, 1, 1, 0, 4, 1'b1);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule